// File: doc/BRIEF.md
# Dictionary-Mirrored Off-Chip Bus Link

This block carries data words across a wide off-chip bus while keeping line switching low. The sending end and the receiving end each hold a small, fully associative dictionary of recently sent words. The two copies are kept identical. When a word to be sent is already in the dictionary, the sender does not drive the word. It flips exactly one data line, line k for dictionary slot k, and raises a sideband flag that marks the transfer as an index. When the word is not in the dictionary, the sender drives the whole word with the flag low. Both ends then write that word into the slot named by a round-robin pointer, and the two pointers advance together.

The top level is a loopback wrapper. A sender and a receiver are joined by the bus wires, and those wires are also brought out so that their activity can be observed. A word presented at the input comes back at the output two clock cycles later. The number of slots must not exceed the bus width, so that each slot owns a line. Elaboration stops with an error if this is violated.

Top module: `vcache_link`

## Requirements
- R1: Each word accepted with `in_valid` high appears on `out_data`, with `out_valid` high, exactly two clock cycles later. Words keep their order. `out_valid` is low in a cycle that follows an idle input cycle by two.
- R2: After reset, the first transfer of any word is a miss: one cycle after it is accepted, `bus_hit` is 0 and `bus_data` equals the word.
- R3: A word found in slot k is sent as a hit. One cycle after it is accepted, `bus_hit` is 1 and `bus_data` equals the previous `bus_data` with only bit k inverted. Bit k is line k, and slot indices start at 0.
- R4: A word not found in any valid slot is sent in full. One cycle later, `bus_hit` is 0 and `bus_data` equals the word.
- R5: Each miss writes the word into the slot named by the replacement pointer. The pointer starts at 0 and goes through 0, 1, …, N-1, then back to 0. Both ends advance it together. After N further distinct misses, a word is evicted and misses again.
- R6: A hit leaves the dictionary and the replacement pointer unchanged. The next miss after a run of hits lands in the slot that follows the last miss's slot.
- R7: In a cycle with `in_valid` low, `bus_valid` goes low one cycle later and `bus_data` keeps its previous value.
- R8: Reset drives `bus_data` to 0 and `bus_valid`, `bus_hit` and `out_valid` to 0. It invalidates every slot at both ends, so a word cached before the reset misses after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered this cycle |
| in_data | input | WIDTH | Word to send |
| bus_valid | output | 1 | Bus carries a transfer this cycle |
| bus_hit | output | 1 | Transfer is a slot index (1) or a full word (0) |
| bus_data | output | WIDTH | Bus data lines |
| out_valid | output | 1 | Decoded word is present |
| out_data | output | WIDTH | Decoded word |

## Verification
The hardest case to reach from the ports is eviction. The round-robin pointer has to wrap past a slot that is still in use, and a word cached earlier then has to be offered again, so that it misses where it had hit before. The directed part of the stimulus fills every slot with distinct words, adds one more, and then replays the first word. It also places a miss after a run of hits, which shows whether a hit moved the pointer. The random part draws from a pool slightly larger than the dictionary, which mixes hits, misses and evictions, with idle gaps in between.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int VC_MAXW = 64;

  // Index of the lowest set bit; 0 when no bit is set.
  function automatic int vc_first_set(input logic [VC_MAXW-1:0] v);
    int r;
    r = 0;
    for (int i = VC_MAXW - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/vc_store.sv
module vc_store #(
  parameter int WIDTH   = 16,
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [WIDTH-1:0] ins_word,
  output logic [WIDTH-1:0] ent_o [ENTRIES],
  output logic [ENTRIES-1:0] vld_o,
  output logic [IW-1:0]    ptr_o
);
  logic [IW-1:0] ptr_next;
  assign ptr_next = (ptr_o == IW'(ENTRIES - 1)) ? '0 : ptr_o + IW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_o <= '0;
    else if (ins_en) ptr_o <= ptr_next;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_o[g] <= 1'b0;
        ent_o[g] <= '0;
      end else if (ins_en && ptr_o == IW'(g)) begin
        vld_o[g] <= 1'b1;
        ent_o[g] <= ins_word;
      end
    end
  end

  // R6: without an insertion the pointer and the valid flags stay put
  assert_hold_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_en |=> $stable(ptr_o) && $stable(vld_o));
  // R5: an insertion fills the slot the pointer named
  assert_insert_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> vld_o[$past(ptr_o)] && ent_o[$past(ptr_o)] == $past(ins_word));
endmodule

// File: rtl/vc_tx.sv
module vc_tx
  import vc_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             bus_valid,
  output logic             bus_hit,
  output logic [WIDTH-1:0] bus_data,
  output logic [IW-1:0]    ptr_o
);
  logic [WIDTH-1:0]   ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic               hit_w;
  logic [IW-1:0]      hit_idx;
  logic               ins_w;

  vc_store #(.WIDTH(WIDTH), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_w), .ins_word(in_data),
    .ent_o(ent), .vld_o(vld), .ptr_o(ptr_o)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (ent[g] == in_data);
  end

  assign hit_w   = |match;
  assign hit_idx = IW'(vc_first_set(VC_MAXW'(match)));
  assign ins_w   = in_valid && !hit_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_hit   <= 1'b0;
      bus_data  <= '0;
    end else begin
      bus_valid <= in_valid;
      if (in_valid) begin
        bus_hit  <= hit_w;
        bus_data <= hit_w ? (bus_data ^ (WIDTH'(1) << hit_idx)) : in_data;
      end
    end
  end

  // R3: a word is never held in two slots
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R3: a hit flips exactly one line
  assert_hit_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hit_w |=> bus_hit && $countones(bus_data ^ $past(bus_data)) == 1);
  // R4: a miss puts the full word on the lines
  assert_miss_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !hit_w |=> !bus_hit && bus_data == $past(in_data));
  // R7: idle cycles leave the lines alone
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !bus_valid && $stable(bus_data));
endmodule

// File: rtl/vc_rx.sv
module vc_rx
  import vc_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_hit,
  input  logic [WIDTH-1:0] bus_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [IW-1:0]    ptr_o
);
  logic [WIDTH-1:0]   ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [WIDTH-1:0]   prev_lines;
  logic [WIDTH-1:0]   flipped;
  logic [IW-1:0]      sel_idx;
  logic               ins_w;

  vc_store #(.WIDTH(WIDTH), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_w), .ins_word(bus_data),
    .ent_o(ent), .vld_o(vld), .ptr_o(ptr_o)
  );

  assign flipped = bus_data ^ prev_lines;
  assign sel_idx = IW'(vc_first_set(VC_MAXW'(flipped)));
  assign ins_w   = bus_valid && !bus_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      prev_lines <= '0;
    end else begin
      out_valid <= bus_valid;
      if (bus_valid) begin
        prev_lines <= bus_data;
        out_data   <= bus_hit ? ent[sel_idx] : bus_data;
      end
    end
  end

  // R3: an index transfer flips one line, and that line names a filled slot
  assert_rx_one_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_hit |-> $countones(flipped) == 1 && vld[sel_idx]);
  // R1: a transfer yields an output word one cycle later
  assert_rx_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> out_valid);
endmodule

// File: rtl/vcache_link.sv
module vcache_link #(
  parameter int WIDTH   = 16,
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             bus_valid,
  output logic             bus_hit,
  output logic [WIDTH-1:0] bus_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  if (ENTRIES > WIDTH || ENTRIES < 1) begin : g_bad_cfg
    $error("vcache_link: ENTRIES must be between 1 and WIDTH");
  end

  logic [IW-1:0] tx_ptr;
  logic [IW-1:0] rx_ptr;

  vc_tx #(.WIDTH(WIDTH), .ENTRIES(ENTRIES)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_valid(bus_valid), .bus_hit(bus_hit), .bus_data(bus_data), .ptr_o(tx_ptr)
  );

  vc_rx #(.WIDTH(WIDTH), .ENTRIES(ENTRIES)) u_rx (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_hit(bus_hit),
    .bus_data(bus_data), .out_valid(out_valid), .out_data(out_data), .ptr_o(rx_ptr)
  );

  // R5: the receiver pointer follows the sender pointer one cycle behind
  assert_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ptr == $past(tx_ptr));
  // R1: output words come two cycles after input words
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_valid) |=> out_valid && out_data == $past(in_data, 2));
endmodule

// File: tb/tb_vcache_link.sv
module tb_vcache_link;
  localparam int W = 16;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic bus_valid, bus_hit, out_valid;
  logic [W-1:0] bus_data, out_data;

  int errors = 0;
  int checks = 0;

  vcache_link #(.WIDTH(W), .ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_valid(bus_valid), .bus_hit(bus_hit), .bus_data(bus_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #10 clk = ~clk;

  // bench model of one end's dictionary
  logic [W-1:0] mc [N];
  logic         mv [N];
  int           mptr;
  logic [W-1:0] mlines;
  // expectations in flight
  logic         pb_v, pb_hit, po_v;
  logic [W-1:0] pb_lines, pb_word, po_word;
  string        pb_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int model_find(input logic [W-1:0] w);
    for (int i = 0; i < N; i++) if (mv[i] && mc[i] == w) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin mv[i] = 1'b0; mc[i] = '0; end
    mptr = 0; mlines = '0;
    pb_v = 1'b0; pb_hit = 1'b0; pb_lines = '0; pb_word = '0; pb_tag = "R8";
    po_v = 1'b0; po_word = '0;
  endtask

  // one cycle: check what the previous drives produced, then drive anew
  task automatic step(input bit v, input logic [W-1:0] w, input string tag);
    int k;
    @(negedge clk);
    check(bus_valid == pb_v, pb_tag, "bus_valid", W'(bus_valid), W'(pb_v));
    check(bus_data == pb_lines, pb_tag, "bus_data", bus_data, pb_lines);
    if (pb_v) check(bus_hit == pb_hit, pb_tag, "bus_hit", W'(bus_hit), W'(pb_hit));
    check(out_valid == po_v, "R1", "out_valid", W'(out_valid), W'(po_v));
    if (po_v) check(out_data == po_word, "R1", "out_data", out_data, po_word);
    po_v = pb_v; po_word = pb_word;
    pb_v = v; pb_word = w;
    if (v) begin
      k = model_find(w);
      if (k >= 0) begin
        mlines = mlines ^ (W'(1) << k);
        pb_hit = 1'b1;
      end else begin
        mlines = w; pb_hit = 1'b0;
        mc[mptr] = w; mv[mptr] = 1'b1;
        mptr = (mptr + 1) % N;
      end
      pb_tag = (tag != "") ? tag : (pb_hit ? "R3" : "R4");
    end else begin
      pb_tag = "R7";
    end
    pb_lines = mlines;
    in_valid = v; in_data = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_data == '0, "R8", "bus_data in reset", bus_data, '0);
    check(!bus_valid && !bus_hit, "R8", "bus flags in reset", W'({bus_valid, bus_hit}), '0);
    check(!out_valid, "R8", "out_valid in reset", W'(out_valid), '0);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] pool [12];
    void'($urandom(32'h5eed_1234));
    model_clear();
    do_reset();

    // first use, repeat, idle gaps
    step(1, 16'hA5A5, "R2");
    step(1, 16'hA5A5, "R3");
    step(0, '0, "R7");
    step(0, '0, "R7");
    step(1, 16'hA5A5, "R3");

    // fill the remaining slots, wrap the pointer, evict the first word
    for (int i = 1; i < N; i++) step(1, W'(16'h1000 + i), "R5");
    step(1, 16'h2000, "R5");
    step(1, 16'hA5A5, "R5");

    // hits must not move the pointer: the next miss lands after the last one
    step(1, 16'h1003, "R6");
    step(1, 16'h1005, "R6");
    step(1, 16'h3333, "R6");
    step(1, 16'h3333, "R6");
    step(1, 16'h1004, "R6");

    // random mix of repeats, misses and idle cycles
    for (int i = 0; i < 12; i++) pool[i] = W'($urandom);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(9) < 8) step(1, pool[$urandom_range(11)], "");
      else step(0, '0, "R7");
    end

    // a cached word must miss after a reset
    step(1, 16'h7777, "");
    step(1, 16'h7777, "R3");
    step(0, '0, "R7");
    step(0, '0, "R7");
    do_reset();
    step(1, 16'h7777, "R8");
    step(1, 16'h7777, "R3");
    step(0, '0, "R7");
    step(0, '0, "R7");
    step(0, '0, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule